// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one read or write column command into the sequence of column addresses that a burst walks through, one per clock, together with a burst-active flag and a read data-valid strobe. A mode word loaded while idle sets the burst length, the counting order (sequential or interleaved), the CAS latency (2 or 3) and an option that limits every write to a single beat. A burst runs to its programmed length unless it is cut short by a burst-stop, by a precharge to the bank it is using, or by a newer column command. A newer command replaces the running burst, so a command on every clock gives random column access.

Bursts issued with auto-precharge may not be interrupted. A precharge or a new column command aimed at such a burst is ignored and reported on a one-cycle protocol-error pulse. A mode load during a burst is handled the same way. Row timing, refresh and the data pins belong to other blocks.

Top module: `burst_colseq`

## Requirements
- R1: After reset, burst_active, rd_valid and proto_err are low, and the mode is length 1, sequential order, CAS latency 2, writes at full length.
- R2: Mode bits [2:0] select the length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page, and 100, 101, 110 give 1 beat. A command accepted in cycle t shows beat 0 (col_out equal to cmd_col) in cycle t+1 and one beat per cycle after that, with burst_active high exactly while beats are shown.
- R3: With mode bit [3] = 0, beat k of a fixed-length burst of length L has column equal to the start column with its low log2(L) bits replaced by (start + k) mod L.
- R4: With mode bit [3] = 1 and length 4 or 8, the low 2 or 3 bits of beat k are the start column's low bits XOR k, with the upper bits unchanged. At lengths 1 and 2 the order equals the sequential order, and a full-page burst is always sequential.
- R5: A full-page burst shows column (start + k) mod 512 on beat k and continues until it is stopped, precharged or replaced.
- R6: With mode bit [9] = 1, every write burst has exactly one beat, while reads keep the programmed length.
- R7: Mode bits [6:4] = 3 select CAS latency 3, and any other value selects 2. A read beat shown in cycle c raises rd_valid in cycle c+CL-1. Write beats never raise rd_valid.
- R8: A stop_cmd in a cycle in which a beat is shown makes that beat the last, with burst_active low in the next cycle. For a read that has shown at least two beats, rd_valid is therefore high for 1 (CL 2) or 2 (CL 3) cycles after the stop cycle.
- R9: A pre_cmd whose pre_bank equals the bank of a running burst without auto-precharge ends it exactly as stop_cmd does. A precharge to another bank has no effect.
- R10: A command arriving while a burst without auto-precharge runs aborts it: the new burst's beat 0 appears in the next cycle with the new column, length and direction. Commands may arrive on consecutive cycles.
- R11: While a burst with auto-precharge runs, a same-bank pre_cmd or a new command is ignored, and proto_err is high in the following cycle. Otherwise proto_err stays low.
- R12: A mode load takes effect for commands from the next cycle on. It is ignored, with proto_err high in the following cycle, when a burst is running or when mode bits [8:7] are not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load mode_word into the mode register |
| mode_word | input | 10 | Mode word: [2:0] length, [3] interleave, [6:4] CAS latency, [8:7] must be 00, [9] single-beat writes |
| cmd_valid | input | 1 | Column command this cycle |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_col | input | COL_W | Start column |
| cmd_autopre | input | 1 | Command carries auto-precharge |
| stop_cmd | input | 1 | Burst stop |
| pre_cmd | input | 1 | Precharge command |
| pre_bank | input | BANK_W | Bank addressed by the precharge |
| col_out | output | COL_W | Column of the current beat, valid while burst_active |
| burst_active | output | 1 | A beat is shown this cycle |
| rd_valid | output | 1 | Read data valid, delayed by the CAS latency |
| proto_err | output | 1 | One-cycle pulse after an illegal interrupt or mode load |

## Verification
The hardest cases to reach are the cut-short endings: a stop or same-bank precharge must land while a read burst has already shown two beats, and the trailing rd_valid count must be seen at both latencies. The stimulus counts idle cycles after each command so that every interrupt falls on a chosen beat. It mixes a precharge to the other bank in, and it aims precharges and new commands at an auto-precharge burst. A mode load is placed inside a running burst, and the following burst then shows whether the old length was kept.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    localparam int MODE_W = 10;

    typedef enum logic [2:0] {
        BL_1    = 3'b000,
        BL_2    = 3'b001,
        BL_4    = 3'b010,
        BL_8    = 3'b011,
        BL_FULL = 3'b111
    } blen_e;

    typedef struct packed {
        blen_e blen;
        logic  ilv;
        logic  cl3;
        logic  wr_one;
    } mode_t;

    localparam mode_t MODE_RESET = '{blen: BL_1, ilv: 1'b0, cl3: 1'b0, wr_one: 1'b0};

    function automatic logic mode_word_ok(input logic [MODE_W-1:0] w);
        return w[8:7] == 2'b00;
    endfunction

    function automatic mode_t decode_mode(input logic [MODE_W-1:0] w);
        mode_t m;
        case (w[2:0])
            3'b001:  m.blen = BL_2;
            3'b010:  m.blen = BL_4;
            3'b011:  m.blen = BL_8;
            3'b111:  m.blen = BL_FULL;
            default: m.blen = BL_1;
        endcase
        m.ilv    = w[3];
        m.cl3    = (w[6:4] == 3'd3);
        m.wr_one = w[9];
        return m;
    endfunction

endpackage

// File: rtl/colseq_mode.sv
module colseq_mode
    import colseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              busy,
    input  logic [MODE_W-1:0] word,
    output mode_t             mode,
    output logic              load_err
);

    logic accept;

    assign accept   = load && !busy && mode_word_ok(word);
    assign load_err = load && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
        end else if (accept) begin
            mode <= decode_mode(word);
        end
    end

endmodule

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
    import colseq_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_autopre,
    input  logic              stop_cmd,
    input  logic              pre_cmd,
    input  logic [BANK_W-1:0] pre_bank,
    output logic              active,
    output logic [COL_W-1:0]  col,
    output logic              beat_rd,
    output logic              cur_ap,
    output logic              intr_err
);

    typedef struct packed {
        logic              act;
        logic              rd;
        logic              ap;
        logic              ilv;
        logic              full;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  start;
        logic [COL_W-1:0]  cnt;
        logic [COL_W-1:0]  mask;
    } burst_t;

    burst_t st_q, st_d;

    function automatic logic [COL_W-1:0] len_mask(input blen_e b);
        case (b)
            BL_2:    return COL_W'(1);
            BL_4:    return COL_W'(3);
            BL_8:    return COL_W'(7);
            BL_FULL: return '1;
            default: return '0;
        endcase
    endfunction

    logic             same_bank, bad_cmd, bad_pre, kill, last, one_shot;
    logic [COL_W-1:0] seq_low, ilv_low;

    assign same_bank = (st_q.bank == pre_bank);
    assign bad_cmd   = cmd_valid && st_q.act && st_q.ap;
    assign bad_pre   = pre_cmd && same_bank && st_q.act && st_q.ap;
    assign kill      = st_q.act && (stop_cmd || (pre_cmd && same_bank && !st_q.ap));
    assign last      = !st_q.full && (st_q.cnt == st_q.mask);
    assign one_shot  = cmd_write && mode.wr_one;

    always_comb begin
        st_d = st_q;
        if (cmd_valid && !bad_cmd) begin
            st_d.act   = 1'b1;
            st_d.rd    = !cmd_write;
            st_d.ap    = cmd_autopre;
            st_d.bank  = cmd_bank;
            st_d.start = cmd_col;
            st_d.cnt   = '0;
            st_d.full  = !one_shot && (mode.blen == BL_FULL);
            st_d.mask  = one_shot ? '0 : len_mask(mode.blen);
            st_d.ilv   = mode.ilv && (mode.blen != BL_FULL);
        end else if (st_q.act) begin
            if (kill || last) begin
                st_d.act = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_low  = (st_q.start + st_q.cnt) & st_q.mask;
    assign ilv_low  = (st_q.start ^ st_q.cnt) & st_q.mask;
    assign col      = (st_q.start & ~st_q.mask) | (st_q.ilv ? ilv_low : seq_low);
    assign active   = st_q.act;
    assign beat_rd  = st_q.act && st_q.rd;
    assign cur_ap   = st_q.act && st_q.ap;
    assign intr_err = bad_cmd || bad_pre;

endmodule

// File: rtl/colseq_rdpipe.sv
module colseq_rdpipe #(
    parameter  int STAGES = 2,
    localparam int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_in,
    input  logic [SEL_W-1:0] sel,
    output logic             valid
);

    logic [STAGES-1:0] taps;

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        logic d, q;
        if (i == 0) begin : g_head
            assign d = beat_in;
        end else begin : g_tail
            assign d = g_stg[i-1].q;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else begin
                q <= d;
            end
        end
        assign taps[i] = q;
    end

    assign valid = taps[sel];

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
    import colseq_pkg::*;
#(
    parameter int COL_W     = 9,
    parameter int BANK_W    = 1,
    parameter int RD_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_autopre,
    input  logic              stop_cmd,
    input  logic              pre_cmd,
    input  logic [BANK_W-1:0] pre_bank,
    output logic [COL_W-1:0]  col_out,
    output logic              burst_active,
    output logic              rd_valid,
    output logic              proto_err
);

    localparam int SEL_W = (RD_STAGES > 1) ? $clog2(RD_STAGES) : 1;

    mode_t            mode_q;
    logic             load_err, intr_err, beat_rd, cur_ap, cur_cl3;
    logic [SEL_W-1:0] lat_sel;

    colseq_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .load     (mode_load),
        .busy     (burst_active),
        .word     (mode_word),
        .mode     (mode_q),
        .load_err (load_err)
    );

    colseq_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode_q),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_bank    (cmd_bank),
        .cmd_col     (cmd_col),
        .cmd_autopre (cmd_autopre),
        .stop_cmd    (stop_cmd),
        .pre_cmd     (pre_cmd),
        .pre_bank    (pre_bank),
        .active      (burst_active),
        .col         (col_out),
        .beat_rd     (beat_rd),
        .cur_ap      (cur_ap),
        .intr_err    (intr_err)
    );

    assign cur_cl3 = mode_q.cl3;
    assign lat_sel = cur_cl3 ? SEL_W'(1) : '0;

    colseq_rdpipe #(.STAGES(RD_STAGES)) u_rdpipe (
        .clk     (clk),
        .rst     (rst),
        .beat_in (beat_rd),
        .sel     (lat_sel),
        .valid   (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            proto_err <= 1'b0;
        end else begin
            proto_err <= load_err || intr_err;
        end
    end

endmodule

// File: rtl/colseq_chk.sv
module colseq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_load,
    input logic             cmd_valid,
    input logic [COL_W-1:0] cmd_col,
    input logic             stop_cmd,
    input logic             burst_active,
    input logic [COL_W-1:0] col_out,
    input logic             rd_valid,
    input logic             proto_err,
    input logic             cur_ap,
    input logic             cur_cl3
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!burst_active && !proto_err && !rd_valid));

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !burst_active) |=> (burst_active && col_out == $past(cmd_col)));

    // R8
    stop_end_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_active && stop_cmd && !cmd_valid) |=> !burst_active);

    // R7
    rd_cl2_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cur_cl3 && !$past(burst_active)) |-> !rd_valid);

    // R11
    ap_cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_active && cur_ap && cmd_valid) |=> proto_err);

    // R11
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(burst_active) || $past(mode_load)));

    // R12
    mode_busy_err_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_active && mode_load) |=> proto_err);

endmodule

bind burst_colseq colseq_chk #(.COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_load    (mode_load),
    .cmd_valid    (cmd_valid),
    .cmd_col      (cmd_col),
    .stop_cmd     (stop_cmd),
    .burst_active (burst_active),
    .col_out      (col_out),
    .rd_valid     (rd_valid),
    .proto_err    (proto_err),
    .cur_ap       (cur_ap),
    .cur_cl3      (cur_cl3)
);

// File: tb/sim_burst_colseq.sv
`timescale 1ns/1ps
module sim_burst_colseq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_load = 1'b0;
    logic [9:0] mode_word = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [0:0] cmd_bank = '0;
    logic [8:0] cmd_col = '0;
    logic       cmd_autopre = 1'b0;
    logic       stop_cmd = 1'b0;
    logic       pre_cmd = 1'b0;
    logic [0:0] pre_bank = '0;
    logic [8:0] col_out;
    logic       burst_active, rd_valid, proto_err;

    burst_colseq u0 (
        .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cmd_autopre(cmd_autopre), .stop_cmd(stop_cmd),
        .pre_cmd(pre_cmd), .pre_bank(pre_bank), .col_out(col_out),
        .burst_active(burst_active), .rd_valid(rd_valid), .proto_err(proto_err)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_act, m_rd, m_ap, m_bank, m_start, m_beat, m_len, m_il;
    int md_len, md_il, md_cl, md_one;
    int e_err, e_rdv, cyc;
    int due[$];

    function automatic int len_of(bit [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col();
        int base, off;
        if (m_len == 0) return (m_start + m_beat) % 512;
        off  = m_start % m_len;
        base = m_start - off;
        if (m_il != 0) return base + (off ^ m_beat);
        return base + ((off + m_beat) % m_len);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_rd = 0; m_ap = 0; m_bank = 0; m_start = 0;
            m_beat = 0; m_len = 1; m_il = 0;
            md_len = 1; md_il = 0; md_cl = 2; md_one = 0;
            e_err = 0; e_rdv = 0; cyc = 0;
            due.delete();
        end else begin
            bit ill_cmd, ill_pre, ill_mode, kill;
            if (m_act != 0 && m_rd != 0) due.push_back(cyc + md_cl - 1);
            ill_cmd  = cmd_valid && m_act != 0 && m_ap != 0;
            ill_pre  = pre_cmd && m_act != 0 && m_ap != 0 && int'(pre_bank) == m_bank;
            ill_mode = mode_load && (m_act != 0 || mode_word[8:7] != 2'b00);
            kill     = m_act != 0 && (stop_cmd || (pre_cmd && int'(pre_bank) == m_bank && m_ap == 0));
            e_err    = (ill_cmd || ill_pre || ill_mode) ? 1 : 0;
            if (cmd_valid && !ill_cmd) begin
                m_act = 1; m_rd = cmd_write ? 0 : 1; m_ap = int'(cmd_autopre);
                m_bank = int'(cmd_bank); m_start = int'(cmd_col); m_beat = 0;
                m_len = (cmd_write && md_one != 0) ? 1 : md_len;
                m_il  = (md_il != 0 && (m_len == 4 || m_len == 8)) ? 1 : 0;
            end else if (m_act != 0) begin
                if (kill || (m_len != 0 && m_beat == m_len - 1)) m_act = 0;
                else m_beat = m_beat + 1;
            end
            if (mode_load && !ill_mode) begin
                md_len = len_of(mode_word[2:0]);
                md_il  = int'(mode_word[3]);
                md_cl  = (mode_word[6:4] == 3'd3) ? 3 : 2;
                md_one = int'(mode_word[9]);
            end
            cyc = cyc + 1;
            while (due.size() > 0 && due[0] < cyc) void'(due.pop_front());
            e_rdv = (due.size() > 0 && due[0] == cyc) ? 1 : 0;
        end
    end

    task automatic chk(string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("burst_active", int'(burst_active), m_act);
            if (m_act != 0) chk("col_out", int'(col_out), exp_col());
            chk("rd_valid", int'(rd_valid), e_rdv);
            chk("proto_err", int'(proto_err), e_err);
        end
    end

    function automatic logic [9:0] mw(int len, bit il, int cl, bit one);
        return {one, 2'b00, 3'(cl), il, 3'(len)};
    endfunction

    task automatic t_idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_cmd(bit wr, bit bk, int col, bit ap);
        cmd_valid = 1'b1; cmd_write = wr; cmd_bank = bk; cmd_col = 9'(col); cmd_autopre = ap;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_autopre = 1'b0;
    endtask

    task automatic t_stop();
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
    endtask

    task automatic t_pre(bit bk);
        pre_cmd = 1'b1; pre_bank = bk;
        @(negedge clk);
        pre_cmd = 1'b0;
    endtask

    task automatic t_mode(logic [9:0] w);
        mode_load = 1'b1; mode_word = w;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog %s: got timeout expected finish", cur_req);
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and default single-beat, CL2 read
        cur_req = "R1";
        t_idle(2);
        t_cmd(0, 0, 5, 0); t_idle(5);
        // R2: each length code, including a reserved one
        cur_req = "R2";
        t_mode(mw(1, 0, 2, 0)); t_cmd(0, 0, 9, 0);  t_idle(5);
        t_mode(mw(2, 0, 2, 0)); t_cmd(0, 0, 6, 0);  t_idle(7);
        t_mode(mw(3, 0, 2, 0)); t_cmd(0, 0, 13, 0); t_idle(11);
        t_mode(mw(5, 0, 2, 0)); t_cmd(0, 0, 20, 0); t_idle(4);
        // R3: sequential wrap inside the aligned block
        cur_req = "R3";
        t_mode(mw(3, 0, 2, 0)); t_cmd(1, 0, 30, 0); t_idle(11);
        t_mode(mw(2, 0, 2, 0)); t_cmd(0, 0, 33, 0); t_idle(7);
        // R4: interleaved order at 4 and 8, no effect at 2 and full page
        cur_req = "R4";
        t_mode(mw(2, 1, 2, 0)); t_cmd(0, 0, 7, 0); t_idle(7);
        t_mode(mw(3, 1, 2, 0)); t_cmd(0, 0, 5, 0); t_idle(11);
        t_mode(mw(1, 1, 2, 0)); t_cmd(0, 0, 3, 0); t_idle(5);
        t_mode(mw(7, 1, 2, 0)); t_cmd(0, 0, 2, 0); t_idle(6); t_stop(); t_idle(5);
        // R5: full page wrapping past column 511
        cur_req = "R5";
        t_mode(mw(7, 0, 2, 0)); t_cmd(0, 0, 510, 0); t_idle(20); t_stop(); t_idle(5);
        // R6: single-beat writes, reads keep the length
        cur_req = "R6";
        t_mode(mw(3, 0, 2, 1)); t_cmd(1, 0, 40, 0); t_idle(4);
        t_cmd(0, 0, 40, 0); t_idle(11);
        t_mode(mw(7, 0, 2, 1)); t_cmd(1, 0, 100, 0); t_idle(4);
        // R7: CAS latency 3, writes, and a non-3 field giving CL2
        cur_req = "R7";
        t_mode(mw(2, 0, 3, 0)); t_cmd(0, 0, 1, 0); t_idle(8);
        t_cmd(1, 0, 1, 0); t_idle(8);
        t_mode(mw(2, 0, 5, 0)); t_cmd(0, 0, 1, 0); t_idle(8);
        // R8: burst stop at both latencies, and right after the command
        cur_req = "R8";
        t_mode(mw(3, 0, 2, 0)); t_cmd(0, 0, 0, 0); t_idle(3); t_stop(); t_idle(6);
        t_mode(mw(3, 0, 3, 0)); t_cmd(0, 0, 0, 0); t_idle(3); t_stop(); t_idle(6);
        t_cmd(0, 0, 17, 0); t_stop(); t_idle(6);
        // R9: precharge to the other bank, then to the burst's bank
        cur_req = "R9";
        t_cmd(0, 1, 50, 0); t_idle(2); t_pre(0); t_idle(1); t_pre(1); t_idle(6);
        t_mode(mw(3, 0, 2, 0)); t_cmd(0, 0, 52, 0); t_idle(2); t_pre(0); t_idle(6);
        // R10: new commands on consecutive cycles
        cur_req = "R10";
        t_cmd(0, 0, 60, 0); t_idle(2);
        for (int i = 0; i < 8; i++) t_cmd(i[0], 0, (i * 37 + 11) % 512, 0);
        t_idle(11);
        // R11: interrupts aimed at an auto-precharge burst
        cur_req = "R11";
        t_cmd(0, 0, 70, 1); t_idle(1); t_pre(0); t_cmd(0, 0, 200, 0); t_idle(10);
        // R12: mode load while busy, and with reserved bits set
        cur_req = "R12";
        t_mode(mw(2, 0, 2, 0)); t_cmd(0, 0, 80, 0); t_idle(1);
        t_mode(mw(3, 0, 2, 0)); t_idle(8);
        t_cmd(0, 0, 90, 0); t_idle(7);
        t_mode(10'b0110100011); t_idle(2);
        t_cmd(0, 0, 91, 0); t_idle(8);
        done = 1;
        summary();
        $finish;
    end

endmodule